// File: doc/BRIEF.md
# Dual-Word Numerically Controlled Oscillator

This block is a sine-wave numerically controlled oscillator that runs on the synthesis clock. On every clock a 48-bit phase accumulator advances by a tuning step. The step is the modulo-2^48 sum of two independent 48-bit words, a center word and an offset word, and each word can be gated to zero on its own. The center term is gated by a synchronous enable. The offset term is gated by an asynchronous pin, which is synchronised and then delayed so that toggling the pin moves the output between two frequencies with a fixed latency. This is meant for binary frequency-shift keying.

A 2-bit asynchronous phase-select input adds a quarter-turn multiple to the phase. It can be used for coarse phase keying, or to make one of two units produce the cosine. The top phase bits drive a quarter-wave sine table that is computed at elaboration. The 16-bit signed amplitude is rounded half-up to 14 bits, saturated, and presented in offset-binary code for a converter. A hold input keeps the accumulator at zero, so several units released on the same clock start from the same phase.

Top module: `nco_dual_word`

## Requirements
- R1: After reset the output is 8192, the offset-binary code for zero. The accumulator starts at phase zero, so with zero tuning words the output stays at 8192.
- R2: The step is (center word when the center enable is high, else 0) plus (offset word when the offset pin is high, else 0), truncated to 48 bits. For example 4000_0000_0000h plus C000_0000_0000h gives a step of zero, and the phase stops advancing.
- R3: The offset pin is active high. While the pin is low, the offset term added to the step is zero.
- R4: A change of the offset pin sampled at clock edge k first shows on the output after edge k+14. The output after edge k+13 still reflects the old step.
- R5: While the center enable is low, the center term added to the step is zero.
- R6: Phase select codes 0, 1, 2 and 3 add 0, 90, 180 and 270 degrees to the two most significant phase bits. A change sampled at edge k first shows on the output after edge k+4.
- R7: Phase bit 47 weighs 180 degrees, and the phase wraps modulo one turn, so the output frequency is f_clk * step / 2^48. A step of 2^45 repeats every 8 samples.
- R8: The output code is 14-bit offset binary, rounded half-up with saturation. Phases of 0 and 180 degrees give 8192, 90 degrees gives 16383, 270 degrees gives 0, 45 and 135 degrees give 13985, and 225 and 315 degrees give 2400.
- R9: While hold is high, the accumulator is zero and the output shows only the selected phase offset. If hold is first sampled low at edge r, the output after edge r+2+m shows phase m*step plus the phase offset, for m >= 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Synthesis clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_word_i | input | 48 | Center tuning word |
| cen_en_i | input | 1 | Center term enable, synchronous |
| ofs_word_i | input | 48 | Offset tuning word |
| ofs_en_i | input | 1 | Offset term enable pin, asynchronous, active high |
| psel_i | input | 2 | Quadrant phase offset select, asynchronous |
| acc_hold_i | input | 1 | Hold the accumulator at zero |
| dout_o | output | 14 | Offset-binary sine sample |

## Verification
All tuning words are multiples of an eighth of a turn. Every sample therefore lands on a point whose code is known exactly, and every run starts from a hold release, so the phase of each sample is known. A single eighth-turn step passes through all eight points. This checks the mirror and sign logic in every quadrant, the saturation at the positive peak and the wrap. Word pairs with the enable and the pin in different combinations separate the two gates from each other and from the modular sum. The sum that cancels to zero shows that the carry out of bit 47 is dropped. Single toggles of the pin and of the phase select, made under a frozen phase, locate the exact edge where each latency ends.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef enum logic [1:0] {
    QUAD_0   = 2'd0,
    QUAD_90  = 2'd1,
    QUAD_180 = 2'd2,
    QUAD_270 = 2'd3
  } quad_e;
endpackage

// File: rtl/nco_step.sv
module nco_step #(
  parameter int ACC_W   = 48,
  parameter int OFS_DLY = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] cen_word_i,
  input  logic             cen_en_i,
  input  logic [ACC_W-1:0] ofs_word_i,
  input  logic             ofs_en_i,
  output logic [ACC_W-1:0] step_o
);
  // first two stages double as synchroniser, the rest align the pin latency
  logic [OFS_DLY-1:0] en_pipe;
  logic               ofs_gate;
  logic [ACC_W-1:0]   cen_term, ofs_term, step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_pipe <= '0;
    else         en_pipe <= {en_pipe[OFS_DLY-2:0], ofs_en_i};
  end

  assign ofs_gate = en_pipe[OFS_DLY-1];
  assign cen_term = cen_en_i ? cen_word_i : '0;
  assign ofs_term = ofs_gate ? ofs_word_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= '0;
    else         step_q <= cen_term + ofs_term;  // carry out dropped
  end

  assign step_o = step_q;

  AST_STEP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_en_i && !ofs_gate) |=> step_q == '0); // R3
  AST_CEN_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cen_en_i && !ofs_gate) |=> step_q == $past(cen_word_i)); // R5
endmodule

// File: rtl/nco_phase.sv
module nco_phase
  import nco_pkg::*;
#(
  parameter int ACC_W  = 48,
  parameter int PH_W   = 12,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] step_i,
  input  logic             hold_i,
  input  logic [1:0]       psel_i,
  output logic [PH_W-1:0]  phase_o
);
  logic [ACC_W-1:0] acc_q;
  quad_e            psel_s [SYNC_N];
  logic [PH_W-1:0]  ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (hold_i) acc_q <= '0;
    else             acc_q <= acc_q + step_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SYNC_N; i++) psel_s[i] <= QUAD_0;
    end else begin
      psel_s[0] <= quad_e'(psel_i);
      for (int i = 1; i < SYNC_N; i++) psel_s[i] <= psel_s[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= acc_q[ACC_W-1 -: PH_W] + {psel_s[SYNC_N-1], {(PH_W-2){1'b0}}};
  end

  assign phase_o = ph_q;

  AST_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> acc_q == '0); // R9
  AST_QUAD_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q[ACC_W-1 -: 2] == 2'b00 && psel_s[SYNC_N-1] == QUAD_180)
      |=> ph_q[PH_W-1 -: 2] == 2'b10); // R6
endmodule

// File: rtl/nco_sine.sv
module nco_sine
  import nco_pkg::*;
#(
  parameter int LUT_AW = 10,
  parameter int AMP_W  = 16,
  localparam int PH_W  = LUT_AW + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [PH_W-1:0]         phase_i,
  output logic signed [AMP_W-1:0] amp_o
);
  localparam int  N       = 1 << LUT_AW;
  localparam int  AMP_MAX = (1 << (AMP_W-1)) - 1;
  localparam real QTR_RAD = 1.5707963267948966;

  // quarter wave, N+1 points so the peak sits in the table
  logic [AMP_W-2:0] tbl [N+1];
  for (genvar i = 0; i <= N; i++) begin : g_tbl
    localparam real ANG = QTR_RAD * i / N;
    localparam int  VAL = $rtoi($sin(ANG) * AMP_MAX + 0.5);
    assign tbl[i] = (AMP_W-1)'(VAL);
  end

  quad_e                   quad;
  logic [LUT_AW-1:0]       frac;
  logic [LUT_AW:0]         idx;
  logic [AMP_W-2:0]        mag;
  logic                    mirror, negate;
  logic signed [AMP_W-1:0] amp_d, amp_q;

  assign quad   = quad_e'(phase_i[PH_W-1 -: 2]);
  assign frac   = phase_i[LUT_AW-1:0];
  assign mirror = (quad == QUAD_90) || (quad == QUAD_270);
  assign negate = (quad == QUAD_180) || (quad == QUAD_270);
  assign idx    = mirror ? ((LUT_AW+1)'(N) - {1'b0, frac}) : {1'b0, frac};
  assign mag    = tbl[idx];
  assign amp_d  = negate ? -$signed({1'b0, mag}) : $signed({1'b0, mag});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) amp_q <= '0;
    else         amp_q <= amp_d;
  end

  assign amp_o = amp_q;

  AST_UPPER_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_i[PH_W-1] |=> amp_q >= 0); // R7
  AST_LOWER_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i[PH_W-1] |=> amp_q <= 0); // R7
endmodule

// File: rtl/nco_quant.sv
module nco_quant #(
  parameter int AMP_W = 16,
  parameter int OUT_W = 14
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [AMP_W-1:0] amp_i,
  output logic [OUT_W-1:0]        dout_o
);
  localparam int DROP = AMP_W - OUT_W;
  localparam int RND  = 1 << (DROP-1);
  localparam logic signed [AMP_W:0] QMAX = (AMP_W+1)'((1 << (OUT_W-1)) - 1);
  localparam logic signed [AMP_W:0] QMIN = -(AMP_W+1)'(1 << (OUT_W-1));
  localparam logic [AMP_W-1:0] AMP_TOP = AMP_W'((1 << (AMP_W-1)) - 1);
  localparam logic [OUT_W-1:0] MID = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [AMP_W:0] sum_w, shr_w;
  logic [OUT_W-1:0]      q_w, dout_q;

  assign sum_w = {amp_i[AMP_W-1], amp_i} + (AMP_W+1)'(RND);
  assign shr_w = sum_w >>> DROP;

  always_comb begin
    if (shr_w > QMAX)      q_w = QMAX[OUT_W-1:0];
    else if (shr_w < QMIN) q_w = QMIN[OUT_W-1:0];
    else                   q_w = shr_w[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dout_q <= MID;
    else         dout_q <= {~q_w[OUT_W-1], q_w[OUT_W-2:0]};  // to offset binary
  end

  assign dout_o = dout_q;

  AST_ZERO_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_i == '0 |=> dout_q == MID); // R8
  AST_PEAK_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_i == $signed(AMP_TOP) |=> dout_q == '1); // R8
endmodule

// File: rtl/nco_dual_word.sv
module nco_dual_word #(
  parameter int ACC_W   = 48,
  parameter int LUT_AW  = 10,
  parameter int AMP_W   = 16,
  parameter int OUT_W   = 14,
  parameter int SYNC_N  = 2,
  parameter int OFS_LAT = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] cen_word_i,
  input  logic             cen_en_i,
  input  logic [ACC_W-1:0] ofs_word_i,
  input  logic             ofs_en_i,
  input  logic [1:0]       psel_i,
  input  logic             acc_hold_i,
  output logic [OUT_W-1:0] dout_o
);
  localparam int PH_W    = LUT_AW + 2;
  // step, accumulator, phase, table and output registers follow the pin delay
  localparam int OFS_DLY = OFS_LAT - 4;

  logic [ACC_W-1:0]        step_w;
  logic [PH_W-1:0]         phase_w;
  logic signed [AMP_W-1:0] amp_w;

  nco_step #(.ACC_W(ACC_W), .OFS_DLY(OFS_DLY)) u_step (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cen_word_i(cen_word_i), .cen_en_i(cen_en_i),
    .ofs_word_i(ofs_word_i), .ofs_en_i(ofs_en_i),
    .step_o(step_w)
  );

  nco_phase #(.ACC_W(ACC_W), .PH_W(PH_W), .SYNC_N(SYNC_N)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .step_i(step_w), .hold_i(acc_hold_i), .psel_i(psel_i),
    .phase_o(phase_w)
  );

  nco_sine #(.LUT_AW(LUT_AW), .AMP_W(AMP_W)) u_sine (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .phase_i(phase_w), .amp_o(amp_w)
  );

  nco_quant #(.AMP_W(AMP_W), .OUT_W(OUT_W)) u_quant (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .amp_i(amp_w), .dout_o(dout_o)
  );
endmodule

// File: tb/nco_dual_word_tb.sv
module nco_dual_word_tb;
  localparam int ACC_W = 48;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n;
  logic [ACC_W-1:0] cen_word, ofs_word;
  logic             cen_en, ofs_en, hold;
  logic [1:0]       psel;
  logic [13:0]      dout;

  nco_dual_word u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cen_word_i(cen_word), .cen_en_i(cen_en),
    .ofs_word_i(ofs_word), .ofs_en_i(ofs_en),
    .psel_i(psel), .acc_hold_i(hold),
    .dout_o(dout)
  );

  typedef struct {
    int          at;
    logic [13:0] val;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  // codes at 0,45,...,315 degrees (R8)
  int   tbl8 [8] = '{8192, 13985, 16383, 13985, 8192, 2400, 0, 2400};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int at, input int v, input string tag);
    exp_t e;
    e.at = at; e.val = 14'(v); e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compare everything due for the current cycle
  always @(negedge clk) begin
    exp_t keep[$];
    keep.delete();
    foreach (sb_q[i]) begin
      if (sb_q[i].at == cyc) begin
        n_chk++;
        if (dout !== sb_q[i].val) begin
          n_fail++;
          $display("FAIL %s cycle %0d: actual %0d expected %0d",
                   sb_q[i].tag, cyc, dout, sb_q[i].val);
        end
      end else begin
        keep.push_back(sb_q[i]);
      end
    end
    sb_q = keep;
  end

  task automatic set_words(input int ce, input logic cen, input int oe, input logic oen,
                           input int q);
    cen_word = ACC_W'(ce) << 45;
    ofs_word = ACC_W'(oe) << 45;
    cen_en   = cen;
    ofs_en   = oen;
    psel     = 2'(q);
  endtask

  // freeze phase, check hold output, release, expect m*e+2q eighths
  task automatic run_seq(input int e, input int q, input int n, input string tag);
    int r;
    hold = 1'b1;
    repeat (20) @(negedge clk);
    for (int j = 1; j <= 3; j++) push(cyc + j, tbl8[(2*q) % 8], "R9");
    repeat (3) @(negedge clk);
    hold = 1'b0;
    r = cyc + 1;
    for (int m = 0; m < n; m++) push(r + 2 + m, tbl8[(m*e + 2*q) % 8], tag);
    repeat (n + 4) @(negedge clk);
  endtask

  initial begin : main
    int k;
    rst_n = 1'b0;
    hold  = 1'b0;
    set_words(0, 1'b0, 0, 1'b0, 0);
    repeat (3) @(negedge clk);
    n_chk++;
    if (dout !== 14'd8192) begin
      n_fail++;
      $display("FAIL R1 reset: actual %0d expected 8192", dout);
    end
    rst_n = 1'b1;
    for (int j = 1; j <= 4; j++) push(cyc + j, 8192, "R1");
    repeat (6) @(negedge clk);

    // eighth-turn step through all quadrants and wrap
    set_words(1, 1'b1, 0, 1'b0, 0);
    run_seq(1, 0, 16, "R7 R8");

    // quadrant offsets
    for (int q = 1; q < 4; q++) begin
      set_words(1, 1'b1, 0, 1'b0, q);
      run_seq(1, q, 8, "R6");
    end

    // modular sum cancels to zero
    set_words(2, 1'b1, 6, 1'b1, 1);
    run_seq(0, 1, 6, "R2");
    // both terms contribute: 1 + 2 eighths
    set_words(1, 1'b1, 2, 1'b1, 0);
    run_seq(3, 0, 8, "R2");

    // pin low drops offset term
    set_words(1, 1'b1, 2, 1'b0, 0);
    run_seq(1, 0, 8, "R3");

    // center enable low drops center term
    set_words(3, 1'b0, 1, 1'b1, 0);
    run_seq(1, 0, 8, "R5");

    // hold/restart with offset phase
    set_words(1, 1'b1, 0, 1'b0, 1);
    run_seq(1, 1, 8, "R9");

    // pin latency: only offset term, phase frozen at zero before the toggle
    set_words(0, 1'b0, 2, 1'b0, 0);
    hold = 1'b1;
    repeat (20) @(negedge clk);
    hold = 1'b0;
    repeat (20) @(negedge clk);
    ofs_en = 1'b1;
    k = cyc + 1;
    push(k + 13, 8192, "R4");
    push(k + 14, 16383, "R4");
    push(k + 15, 8192, "R4");
    push(k + 16, 0, "R4");
    repeat (20) @(negedge clk);

    // phase select latency under hold
    set_words(1, 1'b1, 0, 1'b0, 0);
    hold = 1'b1;
    repeat (20) @(negedge clk);
    psel = 2'd1;
    k = cyc + 1;
    push(k + 3, 8192, "R6");
    push(k + 4, 16383, "R6");
    repeat (8) @(negedge clk);

    repeat (5) @(negedge clk);
    foreach (sb_q[i]) begin
      n_chk++;
      n_fail++;
      $display("FAIL %s unchecked entry: actual none expected %0d", sb_q[i].tag, sb_q[i].val);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog: actual %0d cycles expected completion", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule